// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of a five-stage in-order pipeline, where the operand value comes from. A result can still be in flight in the memory stage or the writeback stage when a younger instruction reaches execute and needs it. The block compares the execute-stage source register numbers against the destination numbers of those two older instructions. It then steers each operand either to the register-file read value or to one of the two in-flight results.

The block is purely combinational. A destination match only counts when the producing instruction actually writes a register, and never when the destination is register zero, which always reads as zero. When both older stages target the same register, the memory-stage value is used, because it belongs to the more recent instruction. The select codes are brought out next to the muxed operands, so that a pipeline can use either form.

Top module: `ex_operand_bypass`

## Requirements
- R1: When neither older stage supplies an operand, that operand's select is 2'b00 and the operand equals its register-file read value.
- R2: When the memory stage writes a nonzero destination equal to the first source number, the first select is 2'b10 and the first operand equals the memory-stage result.
- R3: When the memory stage writes a nonzero destination equal to the second source number, the second select is 2'b10 and the second operand equals the memory-stage result.
- R4: When only the writeback stage writes a nonzero destination equal to a source number, that operand's select is 2'b01 and the operand equals the writeback result.
- R5: A stage whose write-enable is low is never chosen, even if its destination number matches.
- R6: A destination of register 0 is never chosen, even with its write-enable high.
- R7: When both stages qualify for the same operand, the memory stage (select 2'b10) wins.
- R8: The two operands are resolved independently: equal source numbers both forward, and each operand may take a different stage in the same cycle.
- R9: The select code 2'b11 never appears on either select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register number of the instruction in execute |
| src_b_idx | input | 5 | Second source register number of the instruction in execute |
| mem_dst_idx | input | 5 | Destination number of the instruction in the memory stage |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst_idx | input | 5 | Destination number of the instruction in writeback |
| wb_wr_en | input | 1 | Writeback instruction writes a register |
| rf_a_val | input | 32 | Register-file value for the first source |
| rf_b_val | input | 32 | Register-file value for the second source |
| mem_result | input | 32 | ALU result held in the memory stage |
| wb_result | input | 32 | Result value in the writeback stage |
| sel_a | output | 2 | Source select for the first operand (00 file, 10 memory, 01 writeback) |
| sel_b | output | 2 | Source select for the second operand (same coding) |
| opnd_a | output | 32 | First ALU operand after bypass |
| opnd_b | output | 32 | Second ALU operand after bypass |

## Verification
Each operand is driven with a single match in the memory stage and in the writeback stage. This shows that the comparison goes to the right source number and that the right result is steered. Matching numbers with write-enable low, and with destination zero, show that the qualifiers are really applied. Cases where both stages match, or where the operands match in different stages, separate the priority order from independent per-operand resolution. A sweep over all register numbers, with every stage matching, confirms the zero exclusion at the one point where it applies and the absence of the unused select code.

// File: rtl/ex_operand_bypass.sv
module ex_operand_bypass #(
  parameter int REG_IDX_W = 5,
  parameter int DATA_W    = 32
) (
  input  logic [REG_IDX_W-1:0] src_a_idx,
  input  logic [REG_IDX_W-1:0] src_b_idx,
  input  logic [REG_IDX_W-1:0] mem_dst_idx,
  input  logic                 mem_wr_en,
  input  logic [REG_IDX_W-1:0] wb_dst_idx,
  input  logic                 wb_wr_en,
  input  logic [DATA_W-1:0]    rf_a_val,
  input  logic [DATA_W-1:0]    rf_b_val,
  input  logic [DATA_W-1:0]    mem_result,
  input  logic [DATA_W-1:0]    wb_result,
  output logic [1:0]           sel_a,
  output logic [1:0]           sel_b,
  output logic [DATA_W-1:0]    opnd_a,
  output logic [DATA_W-1:0]    opnd_b
);
  localparam int            NUM_SRC  = 2;
  localparam logic [1:0]    PICK_RF  = 2'b00;
  localparam logic [1:0]    PICK_MEM = 2'b10;
  localparam logic [1:0]    PICK_WB  = 2'b01;

  logic mem_live, wb_live;
  logic [REG_IDX_W-1:0] src_idx [NUM_SRC];
  logic [DATA_W-1:0]    rf_val  [NUM_SRC];
  logic [1:0]           pick    [NUM_SRC];
  logic [DATA_W-1:0]    opnd    [NUM_SRC];

  assign mem_live = mem_wr_en && (mem_dst_idx != '0);
  assign wb_live  = wb_wr_en  && (wb_dst_idx  != '0);

  assign src_idx[0] = src_a_idx;
  assign src_idx[1] = src_b_idx;
  assign rf_val[0]  = rf_a_val;
  assign rf_val[1]  = rf_b_val;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic hit_mem, hit_wb;
    assign hit_mem = mem_live && (mem_dst_idx == src_idx[g]);
    assign hit_wb  = wb_live  && (wb_dst_idx  == src_idx[g]);
    assign pick[g] = hit_mem ? PICK_MEM : (hit_wb ? PICK_WB : PICK_RF);

    always_comb begin
      case (pick[g])
        PICK_MEM: opnd[g] = mem_result;
        PICK_WB:  opnd[g] = wb_result;
        default:  opnd[g] = rf_val[g];
      endcase
    end
  end

  assign sel_a  = pick[0];
  assign sel_b  = pick[1];
  assign opnd_a = opnd[0];
  assign opnd_b = opnd[1];
endmodule

module ex_operand_bypass_chk #(
  parameter int REG_IDX_W = 5,
  parameter int DATA_W    = 32
) (
  input logic [REG_IDX_W-1:0] src_a_idx,
  input logic [REG_IDX_W-1:0] src_b_idx,
  input logic [REG_IDX_W-1:0] mem_dst_idx,
  input logic                 mem_wr_en,
  input logic [REG_IDX_W-1:0] wb_dst_idx,
  input logic                 wb_wr_en,
  input logic [DATA_W-1:0]    rf_a_val,
  input logic [DATA_W-1:0]    rf_b_val,
  input logic [DATA_W-1:0]    mem_result,
  input logic [DATA_W-1:0]    wb_result,
  input logic [1:0]           sel_a,
  input logic [1:0]           sel_b,
  input logic [DATA_W-1:0]    opnd_a,
  input logic [DATA_W-1:0]    opnd_b
);
  always_comb begin
    assert_no_code3_R9: assert (sel_a != 2'b11 && sel_b != 2'b11);
    assert_file_path_R1: assert ((sel_a != 2'b00 || opnd_a == rf_a_val) &&
                                 (sel_b != 2'b00 || opnd_b == rf_b_val));
    assert_mem_a_R2: assert (sel_a != 2'b10 ||
                             (mem_wr_en && mem_dst_idx == src_a_idx && opnd_a == mem_result));
    assert_mem_b_R3: assert (sel_b != 2'b10 ||
                             (mem_wr_en && mem_dst_idx == src_b_idx && opnd_b == mem_result));
    assert_wb_pick_R4: assert ((sel_a != 2'b01 || (wb_wr_en && wb_dst_idx == src_a_idx && opnd_a == wb_result)) &&
                               (sel_b != 2'b01 || (wb_wr_en && wb_dst_idx == src_b_idx && opnd_b == wb_result)));
    assert_zero_src_R6: assert ((src_a_idx != '0 || sel_a == 2'b00) &&
                                (src_b_idx != '0 || sel_b == 2'b00));
    assert_younger_wins_R7: assert (!(mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == src_a_idx) ||
                                    sel_a == 2'b10);
    assert_no_enable_R5: assert ((mem_wr_en || sel_a != 2'b10) && (wb_wr_en || sel_b != 2'b01));
  end
endmodule

bind ex_operand_bypass ex_operand_bypass_chk #(.REG_IDX_W(REG_IDX_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_ex_operand_bypass.sv
module tb_ex_operand_bypass;
  localparam logic [31:0] RF_A = 32'hA0A0_0001;
  localparam logic [31:0] RF_B = 32'hB0B0_0002;
  localparam logic [31:0] MEMV = 32'hCC00_0003;
  localparam logic [31:0] WBV  = 32'hDD00_0004;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]  src_a_idx = '0, src_b_idx = '0, mem_dst_idx = '0, wb_dst_idx = '0;
  logic        mem_wr_en = 1'b0, wb_wr_en = 1'b0;
  logic [31:0] rf_a_val = RF_A, rf_b_val = RF_B, mem_result = MEMV, wb_result = WBV;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int checks = 0;
  int fails  = 0;

  ex_operand_bypass dut (
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .mem_dst_idx(mem_dst_idx), .mem_wr_en(mem_wr_en),
    .wb_dst_idx(wb_dst_idx), .wb_wr_en(wb_wr_en),
    .rf_a_val(rf_a_val), .rf_b_val(rf_b_val),
    .mem_result(mem_result), .wb_result(wb_result),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  task automatic drive(input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] md, input logic mw,
                       input logic [4:0] wd, input logic ww);
    @(negedge clk);
    src_a_idx = a; src_b_idx = b;
    mem_dst_idx = md; mem_wr_en = mw;
    wb_dst_idx = wd; wb_wr_en = ww;
    #2;
  endtask

  task automatic expect_pair(input string req, input logic [1:0] ea, input logic [1:0] eb);
    logic [31:0] va, vb;
    va = (ea == 2'b10) ? MEMV : (ea == 2'b01) ? WBV : RF_A;
    vb = (eb == 2'b10) ? MEMV : (eb == 2'b01) ? WBV : RF_B;
    checks++;
    if (sel_a !== ea || opnd_a !== va) begin
      fails++;
      $display("FAIL %s operand A: sel=%b val=%h expected sel=%b val=%h", req, sel_a, opnd_a, ea, va);
    end
    checks++;
    if (sel_b !== eb || opnd_b !== vb) begin
      fails++;
      $display("FAIL %s operand B: sel=%b val=%h expected sel=%b val=%h", req, sel_b, opnd_b, eb, vb);
    end
  endtask

  task automatic t_idle_R1;
    drive(5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1);
    expect_pair("R1", 2'b00, 2'b00);
  endtask

  task automatic t_mem_a_R2;
    drive(5'd3, 5'd2, 5'd3, 1'b1, 5'd0, 1'b0);
    expect_pair("R2", 2'b10, 2'b00);
  endtask

  task automatic t_mem_b_R3;
    drive(5'd6, 5'd7, 5'd7, 1'b1, 5'd9, 1'b1);
    expect_pair("R3", 2'b00, 2'b10);
  endtask

  task automatic t_wb_R4;
    drive(5'd4, 5'd8, 5'd1, 1'b1, 5'd4, 1'b1);
    expect_pair("R4", 2'b01, 2'b00);
    drive(5'd11, 5'd12, 5'd13, 1'b1, 5'd12, 1'b1);
    expect_pair("R4", 2'b00, 2'b01);
  endtask

  task automatic t_no_enable_R5;
    drive(5'd3, 5'd3, 5'd3, 1'b0, 5'd3, 1'b0);
    expect_pair("R5", 2'b00, 2'b00);
    drive(5'd5, 5'd6, 5'd5, 1'b0, 5'd5, 1'b1);
    expect_pair("R5", 2'b01, 2'b00);
  endtask

  task automatic t_reg_zero_R6;
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    expect_pair("R6", 2'b00, 2'b00);
  endtask

  task automatic t_priority_R7;
    drive(5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1);
    expect_pair("R7", 2'b10, 2'b10);
    drive(5'd20, 5'd21, 5'd0, 1'b1, 5'd20, 1'b1);
    expect_pair("R7", 2'b01, 2'b00);
  endtask

  task automatic t_independent_R8;
    drive(5'd9, 5'd9, 5'd9, 1'b1, 5'd2, 1'b1);
    expect_pair("R8", 2'b10, 2'b10);
    drive(5'd14, 5'd15, 5'd14, 1'b1, 5'd15, 1'b1);
    expect_pair("R8", 2'b10, 2'b01);
    drive(5'd15, 5'd14, 5'd14, 1'b1, 5'd15, 1'b1);
    expect_pair("R8", 2'b01, 2'b10);
  endtask

  task automatic t_sweep_R9;
    for (int i = 0; i < 32; i++) begin
      drive(5'(i), 5'(i), 5'(i), 1'b1, 5'(i), 1'b1);
      checks++;
      if (sel_a === 2'b11 || sel_b === 2'b11) begin
        fails++;
        $display("FAIL R9 reg %0d: sel_a=%b sel_b=%b expected neither 11", i, sel_a, sel_b);
      end
      if (i == 0) expect_pair("R6", 2'b00, 2'b00);
      else        expect_pair("R7", 2'b10, 2'b10);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200_000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    checks++;
    if (sel_a !== 2'b00 || sel_b !== 2'b00 || opnd_a !== RF_A || opnd_b !== RF_B) begin
      fails++;
      $display("FAIL R1 initial: sel=%b/%b val=%h/%h expected 00/00 %h/%h",
               sel_a, sel_b, opnd_a, opnd_b, RF_A, RF_B);
    end
    t_idle_R1();
    t_mem_a_R2();
    t_mem_b_R3();
    t_wb_R4();
    t_no_enable_R5();
    t_reg_zero_R6();
    t_priority_R7();
    t_independent_R8();
    t_sweep_R9();
    finish_run();
  end
endmodule